// File: doc/BRIEF.md
# NAND Flash Page Read Sequencer

This block is the bus engine that fetches bytes from an 8-bit asynchronous NAND flash. It handles two operations. A read takes a block, a page, a column and a byte count, and runs the full command, address, wait and data phases on the flash pins. A device reset sends a single command and then waits for the device to settle. The requester raises a start strobe while the block is idle. It then sees `busy` until a one-cycle `done` pulse arrives, and that pulse carries a 2-bit outcome code. Each byte read from the flash comes back on `rdData`, qualified by a one-cycle `rdValid` pulse.

Configuration inputs are sampled when an operation is accepted. They set the following:
- the pre-read, post-read and reset command codes;
- the shifts used to place block, page and column in the 32-bit flash address;
- whether that address is byte-reversed;
- how many address cycles are sent;
- whether a post-address command follows.

Every strobe phase lasts `STD_DELAY` clocks. The block does not sample a ready/busy pin. It waits a fixed `READY_WAIT` clocks instead. The data bus output enable is always released before the flash is told to drive, and it is taken back only after the flash has let go.

Top module: `nand_page_reader`

## Requirements
- R1: After reset, and whenever no operation runs, the pins rest at idle: `nandCeN`, `nandWeN` and `nandReN` are 1; `nandCleO` and `nandAleO` are 0; `nandDqOe` is 1; `busy` and `done` are 0.
- R2: A command byte is written as follows. `nandCleO` is 1 and `nandAleO` is 0 while `nandWeN` is low for exactly 2·STD_DELAY clocks. The byte is on `nandDqOut` when `nandWeN` rises. `nandWeN` low only ever occurs with `nandCeN` low.
- R3: An address byte uses the same write pulse with `nandAleO` at 1 and `nandCleO` at 0. CLE and ALE are never both 1.
- R4: The flash address is the 32-bit sum (block << blockShift) + (page << pageShift) + (column << columnShift), wrapping modulo 2^32. When `cfgLsbFirst` is 0, the four bytes of that word are reversed (byte 0 swaps with byte 3, and byte 1 swaps with byte 2).
- R5: `cfgAddrCycles` address bytes are sent, in this order: word bits 7:0; then {4'h0, bits 11:8}; then bits 23:16; then bits 31:24. A setting of 0 sends one cycle.
- R6: A read first waits 10·STD_DELAY clocks with CE# high. It then lowers CE#, and the first WE# fall follows 5·STD_DELAY clocks later. Next come the pre-read command (`cfgPreCmd`), the address bytes, and then the post-read command (`cfgPostCmd`) only when `cfgPostEn` is 1. Nothing else is written on the bus.
- R7: `byteCount` bytes are read. Between the last WE# rise and the first RE# fall there are 3·STD_DELAY + READY_WAIT clocks. `nandDqOe` is 0 for at least one clock before each RE# fall and stays 0 while RE# is low. It returns to 1 only after RE# is high again. Each byte is sampled while RE# is low and is presented once on `rdData` with `rdValid`. Bytes arrive in bus order. CE# returns high after the last byte.
- R8: A reset operation (`opReset` = 1) writes only `cfgResetCmd` as a command with CE# low. It then raises CE#, waits, and finishes with status 0. No RE# pulse occurs.
- R9: A read with `cfgAddrCycles` above 4 ends with status 2. CE# never falls and no byte is written. This check takes precedence over R10.
- R10: A read whose block is not below `cfgTotalBlocks`, or whose page is not below `cfgPagesPerBlock`, ends with status 1 and no bus activity. A read at block total−1 and page count−1 is accepted.
- R11: Every accepted operation ends with exactly one `done` pulse lasting one clock. Status is 0 on success. A start strobe raised while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request strobe, taken only when idle |
| opReset | input | 1 | 1 = device reset, 0 = read |
| blockIdx | input | IDX_W | Block to read |
| pageIdx | input | IDX_W | Page within block |
| columnIdx | input | IDX_W | First column |
| byteCount | input | LEN_W | Bytes to read |
| cfgPreCmd | input | 8 | Command sent before the address |
| cfgPostCmd | input | 8 | Command sent after the address |
| cfgResetCmd | input | 8 | Device reset command |
| cfgPostEn | input | 1 | Send the post-address command |
| cfgLsbFirst | input | 1 | 0 = byte-reverse the address word |
| cfgAddrCycles | input | 3 | Number of address cycles |
| cfgBlockShift | input | 5 | Block shift |
| cfgPageShift | input | 5 | Page shift |
| cfgColShift | input | 5 | Column shift |
| cfgTotalBlocks | input | IDX_W | Block count limit |
| cfgPagesPerBlock | input | IDX_W | Page count limit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 bad address, 2 bad cycle count |
| nandCeN | output | 1 | Chip enable, active low |
| nandCleO | output | 1 | Command latch enable |
| nandAleO | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write enable, active low |
| nandReN | output | 1 | Read enable, active low |
| nandDqOut | output | 8 | Data bus value driven out |
| nandDqOe | output | 1 | Data bus output enable |
| nandDqIn | input | 8 | Data bus value from the flash |
| rdValid | output | 1 | Read byte strobe |
| rdData | output | 8 | Read byte |

## Verification
The read path is swept over every combination of address-cycle count (1 to 4), byte order and post-command enable. Each combination uses a different block, page and column, different shifts, and a byte count from 0 to 3. Because of this, a wrong byte lane, a missing nibble mask, a swapped reversal or a misplaced post command each produce a different write log from the expected one. Timing is measured on the pins: the CE#-to-WE# gap, the WE# pulse width and the ready interval. These measurements separate a missing or extra phase from a pure ordering fault. Boundary requests cover the following cases: cycle counts of 0, 5 and 7; block and page at their limits and one past them; a request with both error kinds, to show which takes precedence; and a start raised during a read, to show it is ignored.

// File: rtl/nandrd_pkg.sv
package nandrd_pkg;

  localparam int ADDR_CYC_MAX = 4;
  localparam int CYC_IDX_W = 2;

  typedef enum logic [1:0] {
    SRC_PRE  = 2'd0,
    SRC_ADDR = 2'd1,
    SRC_POST = 2'd2,
    SRC_RST  = 2'd3
  } wrSrc_e;

  typedef enum logic [1:0] {
    STS_OK       = 2'd0,
    STS_BAD_ADDR = 2'd1,
    STS_BAD_CYC  = 2'd2
  } opStatus_e;

  // strobes from the sequencer to the pin datapath
  typedef struct packed {
    logic                 loadReq;
    logic                 ceOn;
    logic                 cleOn;
    logic                 aleOn;
    logic                 weLow;
    logic                 reLow;
    logic                 dqRelease;
    logic                 driveDq;
    logic                 captureRd;
    wrSrc_e               src;
    logic [CYC_IDX_W-1:0] addrIdx;
  } busStrobes_t;

endpackage

// File: rtl/nandrd_ctrl.sv
module nandrd_ctrl
  import nandrd_pkg::*;
#(
  parameter int STD_DELAY  = 2,
  parameter int READY_WAIT = 30,
  parameter int IDX_W      = 16,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             opReset,
  input  logic [IDX_W-1:0] blockIdx,
  input  logic [IDX_W-1:0] pageIdx,
  input  logic [LEN_W-1:0] byteCount,
  input  logic [IDX_W-1:0] cfgTotalBlocks,
  input  logic [IDX_W-1:0] cfgPagesPerBlock,
  input  logic [2:0]       cfgAddrCycles,
  input  logic             cfgPostEn,
  output busStrobes_t      strb,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status
);

  localparam int LONGEST = (10 * STD_DELAY > READY_WAIT) ? 10 * STD_DELAY : READY_WAIT;
  localparam int CNT_W = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] LEN_STD   = CNT_W'(STD_DELAY - 1);
  localparam logic [CNT_W-1:0] LEN_CE    = CNT_W'(5 * STD_DELAY - 1);
  localparam logic [CNT_W-1:0] LEN_LEAD  = CNT_W'(10 * STD_DELAY - 1);
  localparam logic [CNT_W-1:0] LEN_READY = CNT_W'(READY_WAIT - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_LEAD, S_CE_ON, S_WR_SETUP, S_WR_DATA, S_WR_HOLD, S_WR_GAP,
    S_READY, S_RD_TURN, S_RD_LOW, S_RD_HIGH, S_RD_BACK, S_CE_OFF, S_DONE
  } seqState_e;

  seqState_e            state, nextState;
  logic [CNT_W-1:0]     phaseCnt;
  logic                 isReset, postEn;
  wrSrc_e               curSrc;
  logic [CYC_IDX_W-1:0] curIdx, lastIdx;
  logic [LEN_W-1:0]     bytesLeft;
  logic [1:0]           statusQ;

  logic phaseEnd, badCyc, badAddr, lastWrite;

  assign phaseEnd = (phaseCnt == '0);
  assign badCyc   = (cfgAddrCycles > 3'd4);
  assign badAddr  = (blockIdx >= cfgTotalBlocks) || (pageIdx >= cfgPagesPerBlock);
  assign lastWrite = (curSrc == SRC_RST) || (curSrc == SRC_POST) ||
                     (curSrc == SRC_ADDR && curIdx == lastIdx && !postEn);

  function automatic logic [CNT_W-1:0] phaseLen(seqState_e s);
    case (s)
      S_LEAD:           return LEN_LEAD;
      S_CE_ON, S_CE_OFF: return LEN_CE;
      S_READY:          return LEN_READY;
      S_IDLE, S_DONE:   return '0;
      default:          return LEN_STD;
    endcase
  endfunction

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE:
        if (startReq) begin
          if (!opReset && (badCyc || badAddr)) nextState = S_DONE;
          else nextState = opReset ? S_CE_ON : S_LEAD;
        end
      S_LEAD:     if (phaseEnd) nextState = S_CE_ON;
      S_CE_ON:    if (phaseEnd) nextState = S_WR_SETUP;
      S_WR_SETUP: if (phaseEnd) nextState = S_WR_DATA;
      S_WR_DATA:  if (phaseEnd) nextState = S_WR_HOLD;
      S_WR_HOLD:  if (phaseEnd) nextState = S_WR_GAP;
      S_WR_GAP:
        if (phaseEnd) begin
          if (!lastWrite) nextState = S_WR_SETUP;
          else nextState = isReset ? S_CE_OFF : S_READY;
        end
      S_READY:
        if (phaseEnd) begin
          if (isReset) nextState = S_DONE;
          else nextState = (bytesLeft != '0) ? S_RD_TURN : S_CE_OFF;
        end
      S_RD_TURN:  if (phaseEnd) nextState = S_RD_LOW;
      S_RD_LOW:   if (phaseEnd) nextState = S_RD_HIGH;
      S_RD_HIGH:  if (phaseEnd) nextState = S_RD_BACK;
      S_RD_BACK:
        if (phaseEnd) nextState = (bytesLeft > LEN_W'(1)) ? S_RD_TURN : S_CE_OFF;
      S_CE_OFF:   if (phaseEnd) nextState = isReset ? S_READY : S_DONE;
      S_DONE:     nextState = S_IDLE;
      default:    nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      phaseCnt  <= '0;
      isReset   <= 1'b0;
      postEn    <= 1'b0;
      curSrc    <= SRC_PRE;
      curIdx    <= '0;
      lastIdx   <= '0;
      bytesLeft <= '0;
      statusQ   <= STS_OK;
    end else begin
      state <= nextState;
      if (state != nextState) phaseCnt <= phaseLen(nextState);
      else if (!phaseEnd) phaseCnt <= phaseCnt - 1'b1;

      if (state == S_IDLE && startReq) begin
        isReset   <= opReset;
        postEn    <= cfgPostEn;
        lastIdx   <= (cfgAddrCycles == 3'd0) ? '0 : CYC_IDX_W'(cfgAddrCycles - 3'd1);
        bytesLeft <= byteCount;
        curSrc    <= opReset ? SRC_RST : SRC_PRE;
        curIdx    <= '0;
        if (opReset) statusQ <= STS_OK;
        else if (badCyc) statusQ <= STS_BAD_CYC;
        else if (badAddr) statusQ <= STS_BAD_ADDR;
        else statusQ <= STS_OK;
      end

      if (state == S_WR_GAP && phaseEnd && !lastWrite) begin
        if (curSrc == SRC_PRE) begin
          curSrc <= SRC_ADDR;
          curIdx <= '0;
        end else if (curIdx != lastIdx) begin
          curIdx <= curIdx + 1'b1;
        end else begin
          curSrc <= SRC_POST;
        end
      end

      if (state == S_RD_BACK && phaseEnd) bytesLeft <= bytesLeft - 1'b1;
    end
  end

  logic inWrite;
  assign inWrite = (state == S_WR_SETUP) || (state == S_WR_DATA) || (state == S_WR_HOLD);

  always_comb begin
    strb.loadReq   = (state == S_IDLE) && startReq;
    strb.ceOn      = (state == S_CE_ON) || inWrite || (state == S_WR_GAP) ||
                     (state == S_RD_TURN) || (state == S_RD_LOW) ||
                     (state == S_RD_HIGH) || (state == S_RD_BACK) ||
                     (state == S_READY && !isReset);
    strb.cleOn     = inWrite && (curSrc != SRC_ADDR);
    strb.aleOn     = inWrite && (curSrc == SRC_ADDR);
    strb.weLow     = (state == S_WR_SETUP) || (state == S_WR_DATA);
    strb.driveDq   = (state == S_WR_DATA);
    strb.reLow     = (state == S_RD_LOW);
    strb.dqRelease = (state == S_RD_TURN) || (state == S_RD_LOW) || (state == S_RD_HIGH);
    strb.captureRd = (state == S_RD_HIGH) && (phaseCnt == LEN_STD);
    strb.src       = curSrc;
    strb.addrIdx   = curIdx;
  end

  assign busy   = (state != S_IDLE);
  assign done   = (state == S_DONE);
  assign status = statusQ;

  // R11: completion pulse lasts one clock
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: an oversized cycle count finishes at once with code 2
  a_r9_bad_cycles: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq && !opReset && cfgAddrCycles > 3'd4) |=> (done && status == 2'd2));

  // R11: a start during an operation leaves the operation running
  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

// File: rtl/nandrd_dpath.sv
module nandrd_dpath
  import nandrd_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrobes_t      strb,
  input  logic [IDX_W-1:0] blockIdx,
  input  logic [IDX_W-1:0] pageIdx,
  input  logic [IDX_W-1:0] columnIdx,
  input  logic [4:0]       cfgBlockShift,
  input  logic [4:0]       cfgPageShift,
  input  logic [4:0]       cfgColShift,
  input  logic             cfgLsbFirst,
  input  logic [7:0]       cfgPreCmd,
  input  logic [7:0]       cfgPostCmd,
  input  logic [7:0]       cfgResetCmd,
  input  logic [7:0]       nandDqIn,
  output logic             nandCeN,
  output logic             nandCleO,
  output logic             nandAleO,
  output logic             nandWeN,
  output logic             nandReN,
  output logic [7:0]       nandDqOut,
  output logic             nandDqOe,
  output logic             rdValid,
  output logic [7:0]       rdData
);

  localparam int WORD_W = 8 * ADDR_CYC_MAX;

  logic [WORD_W-1:0] rawAddr, swapAddr, addrWord;
  logic [7:0]        preCmdQ, postCmdQ, rstCmdQ, wrByte;
  logic [7:0]        cycByte [ADDR_CYC_MAX];

  assign rawAddr = (WORD_W'(blockIdx) << cfgBlockShift) +
                   (WORD_W'(pageIdx) << cfgPageShift) +
                   (WORD_W'(columnIdx) << cfgColShift);

  for (genvar b = 0; b < ADDR_CYC_MAX; b++) begin : g_lane
    assign swapAddr[8*b +: 8] = rawAddr[8*(ADDR_CYC_MAX-1-b) +: 8];
    if (b == 1) begin : g_nib
      assign cycByte[b] = {4'h0, addrWord[8*b +: 4]};
    end else begin : g_full
      assign cycByte[b] = addrWord[8*b +: 8];
    end
  end

  always_comb begin
    case (strb.src)
      SRC_PRE:  wrByte = preCmdQ;
      SRC_POST: wrByte = postCmdQ;
      SRC_RST:  wrByte = rstCmdQ;
      default:  wrByte = cycByte[strb.addrIdx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrWord  <= '0;
      preCmdQ   <= '0;
      postCmdQ  <= '0;
      rstCmdQ   <= '0;
      nandCeN   <= 1'b1;
      nandCleO  <= 1'b0;
      nandAleO  <= 1'b0;
      nandWeN   <= 1'b1;
      nandReN   <= 1'b1;
      nandDqOut <= '0;
      nandDqOe  <= 1'b1;
      rdValid   <= 1'b0;
      rdData    <= '0;
    end else begin
      if (strb.loadReq) begin
        addrWord <= cfgLsbFirst ? rawAddr : swapAddr;
        preCmdQ  <= cfgPreCmd;
        postCmdQ <= cfgPostCmd;
        rstCmdQ  <= cfgResetCmd;
      end
      nandCeN  <= !strb.ceOn;
      nandCleO <= strb.cleOn;
      nandAleO <= strb.aleOn;
      nandWeN  <= !strb.weLow;
      nandReN  <= !strb.reLow;
      nandDqOe <= !strb.dqRelease;
      if (strb.driveDq) nandDqOut <= wrByte;
      rdValid <= strb.captureRd;
      if (strb.captureRd) rdData <= nandDqIn;
    end
  end

  // R3: latch enables never overlap
  a_r3_latch_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCleO && nandAleO));

  // R2: a write pulse only happens while the chip is selected
  a_r2_we_needs_ce: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> !nandCeN);

  // R2: the bus value does not move on the latching edge
  a_r2_dq_stable_at_latch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> $stable(nandDqOut));

  // R7: the bus is released a clock ahead of the read strobe
  a_r7_release_before_re: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandReN) |-> !$past(nandDqOe));

  // R7: no drive while the flash drives
  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandDqOe);

  // R7: drive is retaken only after the read strobe is high
  a_r7_retake_after_re: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandDqOe) |-> $past(nandReN));

endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nandrd_pkg::*;
#(
  parameter int STD_DELAY  = 2,
  parameter int READY_WAIT = 30,
  parameter int IDX_W      = 16,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             opReset,
  input  logic [IDX_W-1:0] blockIdx,
  input  logic [IDX_W-1:0] pageIdx,
  input  logic [IDX_W-1:0] columnIdx,
  input  logic [LEN_W-1:0] byteCount,
  input  logic [7:0]       cfgPreCmd,
  input  logic [7:0]       cfgPostCmd,
  input  logic [7:0]       cfgResetCmd,
  input  logic             cfgPostEn,
  input  logic             cfgLsbFirst,
  input  logic [2:0]       cfgAddrCycles,
  input  logic [4:0]       cfgBlockShift,
  input  logic [4:0]       cfgPageShift,
  input  logic [4:0]       cfgColShift,
  input  logic [IDX_W-1:0] cfgTotalBlocks,
  input  logic [IDX_W-1:0] cfgPagesPerBlock,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status,
  output logic             nandCeN,
  output logic             nandCleO,
  output logic             nandAleO,
  output logic             nandWeN,
  output logic             nandReN,
  output logic [7:0]       nandDqOut,
  output logic             nandDqOe,
  input  logic [7:0]       nandDqIn,
  output logic             rdValid,
  output logic [7:0]       rdData
);

  busStrobes_t strb;

  nandrd_ctrl #(
    .STD_DELAY(STD_DELAY), .READY_WAIT(READY_WAIT), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opReset(opReset),
    .blockIdx(blockIdx), .pageIdx(pageIdx), .byteCount(byteCount),
    .cfgTotalBlocks(cfgTotalBlocks), .cfgPagesPerBlock(cfgPagesPerBlock),
    .cfgAddrCycles(cfgAddrCycles), .cfgPostEn(cfgPostEn),
    .strb(strb), .busy(busy), .done(done), .status(status)
  );

  nandrd_dpath #(.IDX_W(IDX_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .blockIdx(blockIdx), .pageIdx(pageIdx), .columnIdx(columnIdx),
    .cfgBlockShift(cfgBlockShift), .cfgPageShift(cfgPageShift), .cfgColShift(cfgColShift),
    .cfgLsbFirst(cfgLsbFirst), .cfgPreCmd(cfgPreCmd), .cfgPostCmd(cfgPostCmd),
    .cfgResetCmd(cfgResetCmd), .nandDqIn(nandDqIn),
    .nandCeN(nandCeN), .nandCleO(nandCleO), .nandAleO(nandAleO), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandDqOut(nandDqOut), .nandDqOe(nandDqOe),
    .rdValid(rdValid), .rdData(rdData)
  );

  // R7: read bytes appear only inside a selected, running operation
  a_r7_valid_in_op: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (busy && !nandCeN));

endmodule

// File: tb/test_nand_page_reader.sv
`timescale 1ns/1ps
module test_nand_page_reader;

  localparam int D  = 2;
  localparam int RW = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, opReset = 1'b0;
  logic [15:0] blockIdx = '0, pageIdx = '0, columnIdx = '0, byteCount = '0;
  logic [7:0] cfgPreCmd = 8'h00, cfgPostCmd = 8'h30, cfgResetCmd = 8'hFF;
  logic cfgPostEn = 1'b0, cfgLsbFirst = 1'b1;
  logic [2:0] cfgAddrCycles = 3'd4;
  logic [4:0] cfgBlockShift = 5'd0, cfgPageShift = 5'd0, cfgColShift = 5'd0;
  logic [15:0] cfgTotalBlocks = 16'd64, cfgPagesPerBlock = 16'd32;
  logic busy, done, rdValid;
  logic [1:0] status;
  logic nandCeN, nandCleO, nandAleO, nandWeN, nandReN, nandDqOe;
  logic [7:0] nandDqOut, rdData;
  logic [7:0] nandDqIn;

  always #2.5 clk = ~clk;

  nand_page_reader #(.STD_DELAY(D), .READY_WAIT(RW)) i_nand_page_reader (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opReset(opReset),
    .blockIdx(blockIdx), .pageIdx(pageIdx), .columnIdx(columnIdx), .byteCount(byteCount),
    .cfgPreCmd(cfgPreCmd), .cfgPostCmd(cfgPostCmd), .cfgResetCmd(cfgResetCmd),
    .cfgPostEn(cfgPostEn), .cfgLsbFirst(cfgLsbFirst), .cfgAddrCycles(cfgAddrCycles),
    .cfgBlockShift(cfgBlockShift), .cfgPageShift(cfgPageShift), .cfgColShift(cfgColShift),
    .cfgTotalBlocks(cfgTotalBlocks), .cfgPagesPerBlock(cfgPagesPerBlock),
    .busy(busy), .done(done), .status(status),
    .nandCeN(nandCeN), .nandCleO(nandCleO), .nandAleO(nandAleO), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandDqOut(nandDqOut), .nandDqOe(nandDqOe), .nandDqIn(nandDqIn),
    .rdValid(rdValid), .rdData(rdData)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] devByte(int k);
    return 8'((k * 37 + 90) & 255);
  endfunction

  // bus monitor and flash model state
  int evN, rdN, rdIdx, doneN, ceFalls, viol, lastStatus;
  int evKind [16];
  logic [7:0] evByte [16];
  logic [7:0] rdLog [16];
  int tCeFall, tWeFall, tWeRise, firstWeFall, weWidth, readyGap;
  logic pWe = 1'b1, pCe = 1'b1, pRe = 1'b1, pOe = 1'b1;

  assign nandDqIn = nandReN ? 8'h00 : devByte(rdIdx);

  task automatic clearLog();
    evN = 0; rdN = 0; rdIdx = 0; doneN = 0; ceFalls = 0; viol = 0; lastStatus = -1;
    tCeFall = -1; tWeFall = -1; tWeRise = -1; firstWeFall = -1; weWidth = -1; readyGap = -1;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (pCe && !nandCeN) begin ceFalls++; tCeFall = cyc; end
      if (pWe && !nandWeN) begin
        tWeFall = cyc;
        if (firstWeFall < 0) firstWeFall = cyc;
      end
      if (!pWe && nandWeN) begin
        weWidth = cyc - tWeFall;
        tWeRise = cyc;
        if (evN < 16) begin
          evKind[evN] = nandCleO ? 1 : (nandAleO ? 2 : 3);
          evByte[evN] = nandDqOut;
        end
        evN++;
      end
      if (pRe && !nandReN) begin
        if (readyGap < 0) readyGap = cyc - tWeRise;
        if (pOe) viol++;
      end
      if (!pRe && nandReN) rdIdx++;
      if (!nandReN && nandDqOe) viol++;
      if (!pOe && nandDqOe && !pRe) viol++;
      if (rdValid) begin
        if (rdN < 16) rdLog[rdN] = rdData;
        rdN++;
      end
      if (done) begin doneN++; lastStatus = int'(status); end
    end
    pWe = nandWeN; pCe = nandCeN; pRe = nandReN; pOe = nandDqOe;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic isRst, input bit extraStart);
    clearLog();
    @(negedge clk);
    opReset = isRst; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (extraStart) begin
      repeat (5) @(negedge clk);
      opReset = 1'b1; startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0; opReset = isRst;
    end
    for (int w = 0; w < 2000 && doneN == 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // checks the logged bus traffic of a completed read against the request
  task automatic checkRead(input string tag);
    logic [31:0] a;
    logic [7:0] expB [6];
    int expK [6];
    int n, nc;
    a = (32'(blockIdx) << cfgBlockShift) + (32'(pageIdx) << cfgPageShift) +
        (32'(columnIdx) << cfgColShift);
    if (!cfgLsbFirst) a = {a[7:0], a[15:8], a[23:16], a[31:24]};
    nc = (cfgAddrCycles == 3'd0) ? 1 : int'(cfgAddrCycles);
    n = 0;
    expK[n] = 1; expB[n] = cfgPreCmd; n++;
    for (int c = 0; c < nc; c++) begin
      expK[n] = 2;
      case (c)
        0: expB[n] = a[7:0];
        1: expB[n] = {4'h0, a[11:8]};
        2: expB[n] = a[23:16];
        default: expB[n] = a[31:24];
      endcase
      n++;
    end
    if (cfgPostEn) begin expK[n] = 1; expB[n] = cfgPostCmd; n++; end
    chk(evN == n, "R6", {tag, " write count"}, evN, n);
    for (int i = 0; i < n && i < evN; i++) begin
      chk(evKind[i] == expK[i], (expK[i] == 2) ? "R3" : "R2", {tag, " write kind"}, evKind[i], expK[i]);
      chk(evByte[i] == expB[i], (expK[i] == 2) ? "R5" : "R6", {tag, " write byte"},
          int'(evByte[i]), int'(expB[i]));
    end
    chk(rdN == int'(byteCount), "R7", {tag, " read count"}, rdN, int'(byteCount));
    for (int i = 0; i < rdN && i < 16; i++)
      chk(rdLog[i] == devByte(i), "R7", {tag, " read data"}, int'(rdLog[i]), int'(devByte(i)));
    chk(viol == 0, "R7", {tag, " bus turnaround"}, viol, 0);
    chk(doneN == 1, "R11", {tag, " done pulses"}, doneN, 1);
    chk(lastStatus == 0, "R11", {tag, " status"}, lastStatus, 0);
    chk(nandCeN == 1'b1, "R1", {tag, " ce released"}, int'(nandCeN), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clearLog();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 idle levels
    chk(nandCeN && nandWeN && nandReN && !nandCleO && !nandAleO && nandDqOe && !busy && !done,
        "R1", "idle pins", {nandCeN, nandWeN, nandReN, nandCleO, nandAleO, nandDqOe, busy, done},
        8'b11100100);

    // sweep over cycle count, byte order and post command (R4, R5, R6, R7)
    for (int c = 1; c <= 4; c++)
      for (int l = 0; l < 2; l++)
        for (int p = 0; p < 2; p++) begin
          cfgAddrCycles = 3'(c); cfgLsbFirst = l[0]; cfgPostEn = p[0];
          blockIdx = 16'(3 + c * 5 + l); pageIdx = 16'(5 + 2 * l + p * 7);
          columnIdx = 16'(17 * c + 3 * p + 300 * l);
          cfgBlockShift = 5'(14 + 2 * c); cfgPageShift = 5'(6 + 3 * l + p);
          cfgColShift = 5'(p + l);
          byteCount = 16'((c + p + l) % 4);
          cfgPreCmd = 8'(16 * c + l); cfgPostCmd = 8'(48 + c + p);
          runOp(1'b0, 1'b0);
          checkRead("R4 sweep");
          if (c == 4 && l == 1 && p == 0) begin
            chk(tCeFall >= 0 && firstWeFall - tCeFall == 5 * D, "R6", "ce to first we", firstWeFall - tCeFall, 5 * D);
            chk(weWidth == 2 * D, "R2", "we low width", weWidth, 2 * D);
            chk(readyGap == 3 * D + RW, "R7", "ready interval", readyGap, 3 * D + RW);
          end
        end

    // R5: zero cycles acts as one
    cfgAddrCycles = 3'd0; cfgPostEn = 1'b1; byteCount = 16'd2;
    blockIdx = 16'd9; pageIdx = 16'd4; columnIdx = 16'h0ABC; cfgLsbFirst = 1'b1;
    runOp(1'b0, 1'b0);
    checkRead("R5 zero cycles");

    // R10: limits
    cfgAddrCycles = 3'd3; blockIdx = 16'd63; pageIdx = 16'd31; byteCount = 16'd1;
    runOp(1'b0, 1'b0);
    checkRead("R10 last valid");
    blockIdx = 16'd64;
    runOp(1'b0, 1'b0);
    chk(lastStatus == 1, "R10", "block limit status", lastStatus, 1);
    chk(evN == 0 && ceFalls == 0, "R10", "block limit bus idle", evN + ceFalls, 0);
    blockIdx = 16'd2; pageIdx = 16'd32;
    runOp(1'b0, 1'b0);
    chk(lastStatus == 1, "R10", "page limit status", lastStatus, 1);
    chk(evN == 0 && ceFalls == 0 && rdN == 0, "R10", "page limit bus idle", evN + ceFalls + rdN, 0);

    // R9: oversized cycle counts, and precedence over R10
    for (int k = 5; k <= 7; k += 2) begin
      cfgAddrCycles = 3'(k); pageIdx = 16'd1;
      runOp(1'b0, 1'b0);
      chk(lastStatus == 2, "R9", "cycle count status", lastStatus, 2);
      chk(evN == 0 && ceFalls == 0, "R9", "cycle count bus idle", evN + ceFalls, 0);
    end
    pageIdx = 16'd40;
    runOp(1'b0, 1'b0);
    chk(lastStatus == 2, "R9", "precedence status", lastStatus, 2);
    chk(doneN == 1, "R11", "error done pulses", doneN, 1);

    // R8: device reset
    cfgAddrCycles = 3'd2; pageIdx = 16'd3; cfgResetCmd = 8'hA5;
    runOp(1'b1, 1'b0);
    chk(evN == 1, "R8", "reset write count", evN, 1);
    chk(evKind[0] == 1 && evByte[0] == 8'hA5, "R8", "reset command", int'(evByte[0]), 165);
    chk(rdN == 0 && rdIdx == 0, "R8", "reset reads", rdN + rdIdx, 0);
    chk(lastStatus == 0 && doneN == 1, "R8", "reset status", lastStatus, 0);

    // R11: start while busy is ignored
    cfgAddrCycles = 3'd2; cfgPostEn = 1'b0; byteCount = 16'd3; blockIdx = 16'd7;
    runOp(1'b0, 1'b1);
    checkRead("R11 busy start");
    @(negedge clk);
    chk(!busy, "R11", "idle after op", int'(busy), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule